// File: doc/BRIEF.md
# General-Purpose I/O Bank with Change Interrupts

This block manages a bank of up to 32 general-purpose pins behind a small word-addressed register bus. Each pin is either handed to an on-chip peripheral or driven by the bank's own output and output-enable bits. A pin can also be switched to open-drain drive, so other devices can share the wire. On the input side, every pin passes through a two-flop synchronizer. An optional per-pin glitch filter follows it and suppresses pulses shorter than a set number of cycles.

Every pin is watched for level changes, whoever drives it. A change sets a bit in a pending register, and that register empties itself when it is read. A mask register, loaded through separate enable and disable addresses, selects which pending bits raise the single interrupt output. All configuration follows the same pattern. A write of ones to a "set" address turns bits on, and a write to the paired "clear" address turns them off. A third, read-only address returns the current state.

Top module: `gpio_port`

## Requirements
- R1: Each configuration field (ownership, output enable, output data, filter, interrupt mask, open-drain) has a set address and a clear address. Writing a 1 to a bit position sets or clears that bit. A 0 bit leaves it unchanged. The paired status address reads back the field. Word addresses: 0/1/2 ownership set/clear/status (1 = bank drives the pin, 0 = peripheral), 3/4/5 output enable, 6/7/8 filter, 9/10/11 output data, 12/13/14 interrupt enable/disable/mask, 15 pending, 16/17/18 open-drain, 19 conditioned pin level.
- R2: Bits at or above NUM_LINES ignore writes and always read as 0.
- R3: A level change on a pin's conditioned input sets its pending bit at the third rising clock edge after the pad changes, when the filter is off. This happens whatever the pin's owner or output enable. A pending bit stays set until the pending register is read.
- R4: A read of the pending register returns its contents. The clock edge that ends the read clears every bit.
- R5: A change whose pending bit would be set at the same edge as a read-clear stays set after that edge.
- R6: The output irq is high exactly when some pending bit has its mask bit set. Disabling a mask bit keeps the pending bit but removes it from irq.
- R7: Without open-drain, pad_out/pad_oe carry the output-data/output-enable bits when the bank owns the pin. They carry per_out/per_oe when the peripheral owns it.
- R8: With open-drain on, pad_out is 0. pad_oe is high only when the selected output enable is high and the selected output value is 0. This applies to both owners.
- R9: With the filter on, the conditioned level follows the synchronized input only after the two have differed for FILT_CYC consecutive cycles. A pulse of FILT_CYC-1 cycles raises no pending bit, and a pulse of FILT_CYC cycles does.
- R10: After reset all fields and the pending register read 0, irq is low and, with per_oe low, pad_oe is 0.
- R11: Address 19 and per_in show the conditioned input. With the filter off, they take a new pad value at the second rising edge after the pad changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| pad_in | input | NUM_LINES | Pad input levels |
| pad_out | output | NUM_LINES | Pad output data |
| pad_oe | output | NUM_LINES | Pad output enable |
| per_out | input | NUM_LINES | Peripheral output data |
| per_oe | input | NUM_LINES | Peripheral output enable |
| per_in | output | NUM_LINES | Conditioned input toward the peripheral |
| irq | output | 1 | Combined change interrupt |

## Verification
The hardest case to reach is a pad change whose pending bit lands on exactly the edge that ends a read of the pending register. The bench counts edges from the pad toggle. It holds a read during the cycle after the second edge, when the event is live but not yet stored. The read data must not show the bit, and a later read must. Filter boundaries are handled the same way, with pulses held for exactly FILT_CYC-1 and FILT_CYC cycles.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int DW = 32;

    typedef enum logic [4:0] {
        A_OWN_SET = 5'd0,  A_OWN_CLR = 5'd1,  A_OWN_ST = 5'd2,
        A_OE_SET  = 5'd3,  A_OE_CLR  = 5'd4,  A_OE_ST  = 5'd5,
        A_FLT_SET = 5'd6,  A_FLT_CLR = 5'd7,  A_FLT_ST = 5'd8,
        A_DO_SET  = 5'd9,  A_DO_CLR  = 5'd10, A_DO_ST  = 5'd11,
        A_IEN     = 5'd12, A_IDIS    = 5'd13, A_IMSK   = 5'd14,
        A_CHG     = 5'd15,
        A_OD_SET  = 5'd16, A_OD_CLR  = 5'd17, A_OD_ST  = 5'd18,
        A_LVL     = 5'd19
    } gpio_addr_e;

    typedef struct packed {
        logic [DW-1:0] own;
        logic [DW-1:0] oe;
        logic [DW-1:0] flt;
        logic [DW-1:0] dout;
        logic [DW-1:0] msk;
        logic [DW-1:0] od;
        logic [DW-1:0] chg;
    } regs_t;
endpackage

// File: rtl/gpio_in_cond.sv
module gpio_in_cond #(
    parameter int NUM_LINES = 8,
    parameter int FILT_CYC  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pad_in,
    input  logic [NUM_LINES-1:0] flt_en,
    output logic [NUM_LINES-1:0] level
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic          s1_q, s1_d, s2_q, s2_d, f_q, f_d;
        logic [CW-1:0] cnt_q, cnt_d;

        always_comb begin
            s1_d  = pad_in[i];
            s2_d  = s1_q;
            f_d   = f_q;
            cnt_d = '0;
            if (s2_q != f_q) begin
                if (cnt_q == LAST) begin
                    f_d = s2_q;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q  <= 1'b0;
                s2_q  <= 1'b0;
                f_q   <= 1'b0;
                cnt_q <= '0;
            end else begin
                s1_q  <= s1_d;
                s2_q  <= s2_d;
                f_q   <= f_d;
                cnt_q <= cnt_d;
            end
        end

        assign level[i] = flt_en[i] ? f_q : s2_q;
    end
endmodule

// File: rtl/gpio_chg_det.sv
module gpio_chg_det #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] level,
    output logic [NUM_LINES-1:0] evt
);
    logic [NUM_LINES-1:0] prev_q, prev_d;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign evt = level ^ prev_q;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int NUM_LINES = 8
) (
    input  logic [NUM_LINES-1:0] own,
    input  logic [NUM_LINES-1:0] io_dout,
    input  logic [NUM_LINES-1:0] io_oe,
    input  logic [NUM_LINES-1:0] per_out,
    input  logic [NUM_LINES-1:0] per_oe,
    input  logic [NUM_LINES-1:0] od,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_pin
        logic want_out, want_oe;
        always_comb begin
            want_out = own[i] ? io_dout[i] : per_out[i];
            want_oe  = own[i] ? io_oe[i]   : per_oe[i];
            if (od[i]) begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = want_oe & ~want_out;
            end else begin
                pad_out[i] = want_out;
                pad_oe[i]  = want_oe;
            end
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int FILT_CYC  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [4:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe,
    input  logic [NUM_LINES-1:0] per_out,
    input  logic [NUM_LINES-1:0] per_oe,
    output logic [NUM_LINES-1:0] per_in,
    output logic                 irq
);
    localparam logic [DW-1:0] IMPL = {DW{1'b1}} >> (DW - NUM_LINES);

    regs_t                r_q, r_d;
    gpio_addr_e           addr;
    logic                 rd_chg;
    logic [DW-1:0]        wmask, evt_w, lvl_w;
    logic [NUM_LINES-1:0] level, evt;

    assign addr   = gpio_addr_e'(bus_addr);
    assign rd_chg = bus_sel && !bus_wr && (addr == A_CHG);
    assign wmask  = bus_wdata & IMPL;

    gpio_in_cond #(.NUM_LINES(NUM_LINES), .FILT_CYC(FILT_CYC)) u_in (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .flt_en (r_q.flt[NUM_LINES-1:0]),
        .level  (level)
    );

    gpio_chg_det #(.NUM_LINES(NUM_LINES)) u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .level (level),
        .evt   (evt)
    );

    gpio_pad_mux #(.NUM_LINES(NUM_LINES)) u_mux (
        .own     (r_q.own[NUM_LINES-1:0]),
        .io_dout (r_q.dout[NUM_LINES-1:0]),
        .io_oe   (r_q.oe[NUM_LINES-1:0]),
        .per_out (per_out),
        .per_oe  (per_oe),
        .od      (r_q.od[NUM_LINES-1:0]),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    always_comb begin
        evt_w = '0;
        lvl_w = '0;
        evt_w[NUM_LINES-1:0] = evt;
        lvl_w[NUM_LINES-1:0] = level;
    end

    always_comb begin
        r_d = r_q;
        if (bus_sel && bus_wr) begin
            case (addr)
                A_OWN_SET: r_d.own  = r_q.own  | wmask;
                A_OWN_CLR: r_d.own  = r_q.own  & ~wmask;
                A_OE_SET:  r_d.oe   = r_q.oe   | wmask;
                A_OE_CLR:  r_d.oe   = r_q.oe   & ~wmask;
                A_FLT_SET: r_d.flt  = r_q.flt  | wmask;
                A_FLT_CLR: r_d.flt  = r_q.flt  & ~wmask;
                A_DO_SET:  r_d.dout = r_q.dout | wmask;
                A_DO_CLR:  r_d.dout = r_q.dout & ~wmask;
                A_IEN:     r_d.msk  = r_q.msk  | wmask;
                A_IDIS:    r_d.msk  = r_q.msk  & ~wmask;
                A_OD_SET:  r_d.od   = r_q.od   | wmask;
                A_OD_CLR:  r_d.od   = r_q.od   & ~wmask;
                default:   ;
            endcase
        end
        r_d.chg = ((rd_chg ? '0 : r_q.chg) | evt_w) & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (addr)
            A_OWN_ST: bus_rdata = r_q.own;
            A_OE_ST:  bus_rdata = r_q.oe;
            A_FLT_ST: bus_rdata = r_q.flt;
            A_DO_ST:  bus_rdata = r_q.dout;
            A_IMSK:   bus_rdata = r_q.msk;
            A_CHG:    bus_rdata = r_q.chg;
            A_OD_ST:  bus_rdata = r_q.od;
            A_LVL:    bus_rdata = lvl_w;
            default:  bus_rdata = '0;
        endcase
    end

    assign per_in = level;
    assign irq    = |(r_q.chg & r_q.msk);
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_chg,
    input logic [NUM_LINES-1:0] evt,
    input regs_t                regs,
    input logic [NUM_LINES-1:0] pad_out,
    input logic                 irq
);
    localparam logic [DW-1:0] IMPL = {DW{1'b1}} >> (DW - NUM_LINES);

    // R4
    chg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_chg && evt == '0) |=> (regs.chg == '0));

    // R5
    chg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_chg |=> ((regs.chg[NUM_LINES-1:0] & $past(evt)) == $past(evt)));

    // R3
    chg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_chg |=> ((regs.chg & $past(regs.chg)) == $past(regs.chg)));

    // R6
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.msk == '0) |-> !irq);

    // R6
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.chg == '0) |-> !irq);

    // R8
    od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & regs.od[NUM_LINES-1:0]) == '0));

    // R2
    impl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((regs.own | regs.oe | regs.flt | regs.dout | regs.msk | regs.od | regs.chg)
          & ~IMPL) == '0));
endmodule

bind gpio_port gpio_port_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_chg  (rd_chg),
    .evt     (evt),
    .regs    (r_q),
    .pad_out (pad_out),
    .irq     (irq)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    import gpio_pkg::*;
    localparam int N  = 8;
    localparam int FC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0, bus_rdata;
    logic [N-1:0]  pad_in = '0, pad_out, pad_oe, per_out = '0, per_oe = '0, per_in;
    logic          irq;
    int            n_chk = 0, n_bad = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    gpio_port #(.NUM_LINES(N), .FILT_CYC(FC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .per_out(per_out), .per_oe(per_oe), .per_in(per_in), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic put_bit(input logic [4:0] set_a, input logic [4:0] clr_a, input logic v);
        bus_write(v ? set_a : clr_a, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp_o, exp_e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        bus_read(A_OWN_ST, d); chk("R10 own", d, 0);
        bus_read(A_OE_ST, d);  chk("R10 oe", d, 0);
        bus_read(A_FLT_ST, d); chk("R10 flt", d, 0);
        bus_read(A_DO_ST, d);  chk("R10 dout", d, 0);
        bus_read(A_IMSK, d);   chk("R10 mask", d, 0);
        bus_read(A_OD_ST, d);  chk("R10 od", d, 0);
        bus_read(A_CHG, d);    chk("R10 chg", d, 0);
        chk("R10 irq", {31'b0, irq}, 0);
        chk("R10 pad_oe", {24'b0, pad_oe}, 0);

        // R1 set/clear pairs
        bus_write(A_DO_SET, 32'hA5); bus_read(A_DO_ST, d); chk("R1 set", d, 32'hA5);
        bus_write(A_DO_CLR, 32'h05); bus_read(A_DO_ST, d); chk("R1 clr", d, 32'hA0);
        bus_write(A_DO_SET, 32'h5A); bus_read(A_DO_ST, d); chk("R1 set2", d, 32'hFA);
        bus_write(A_DO_CLR, 32'hFF);

        // R2 unimplemented bits
        bus_write(A_OE_SET, 32'hFFFF_FFFF); bus_read(A_OE_ST, d); chk("R2 oe", d, 32'hFF);
        bus_write(A_OD_SET, 32'hFFFF_FF00); bus_read(A_OD_ST, d); chk("R2 od", d, 32'h0);
        bus_write(A_IEN, 32'hFFFF_FFFF);    bus_read(A_IMSK, d);  chk("R2 mask", d, 32'hFF);
        bus_write(A_OE_CLR, 32'hFFFF_FFFF);

        // R11 conditioned level latency
        @(negedge clk); pad_in = 8'h3C;
        @(negedge clk); chk("R11 per_in old", {24'b0, per_in}, 0);
        @(negedge clk); chk("R11 per_in new", {24'b0, per_in}, 32'h3C);
        bus_read(A_LVL, d); chk("R11 level reg", d, 32'h3C);
        repeat (2) @(negedge clk);
        bus_read(A_CHG, d); chk("R3 multi change", d, 32'h3C);

        // R3 exact latency via irq (mask all on)
        @(negedge clk); pad_in[6] = 1'b1;
        @(negedge clk);
        @(negedge clk); chk("R3 before", {31'b0, irq}, 0);
        @(negedge clk); chk("R3 at edge3", {31'b0, irq}, 1);
        bus_read(A_CHG, d); chk("R3 bit6", d, 32'h40);
        chk("R4 irq after read", {31'b0, irq}, 0);
        bus_read(A_CHG, d); chk("R4 cleared", d, 0);

        // R3 sweep over lines, mixed ownership and direction
        bus_write(A_OWN_SET, 32'h55);
        bus_write(A_OE_SET, 32'h0F);
        per_oe = 8'hF0;
        for (int i = 0; i < N; i++) begin
            @(negedge clk); pad_in[i] = ~pad_in[i];
            repeat (4) @(negedge clk);
            chk($sformatf("R6 irq line%0d", i), {31'b0, irq}, 1);
            bus_read(A_CHG, d); chk($sformatf("R3 line%0d", i), d, 32'h1 << i);
            chk($sformatf("R4 irq clr line%0d", i), {31'b0, irq}, 0);
        end

        // R6 masking
        bus_write(A_IDIS, 32'h04);
        bus_read(A_IMSK, d); chk("R6 mask read", d, 32'hFB);
        @(negedge clk); pad_in[2] = ~pad_in[2];
        repeat (4) @(negedge clk);
        chk("R6 masked irq", {31'b0, irq}, 0);
        bus_write(A_IEN, 32'h04);
        chk("R6 unmasked irq", {31'b0, irq}, 1);
        bus_read(A_CHG, d); chk("R6 pending kept", d, 32'h04);

        // R5 event on the same edge as read-clear
        @(negedge clk); pad_in[1] = ~pad_in[1];
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_CHG;
        #1 chk("R5 read during event", bus_rdata, 0);
        @(negedge clk); bus_sel = 1'b0;
        bus_read(A_CHG, d); chk("R5 event kept", d, 32'h02);

        // R9 filter boundaries on line 0
        bus_write(A_FLT_SET, 32'h01);
        bus_read(A_FLT_ST, d); chk("R9 flt status", d, 32'h01);
        for (int k = FC - 1; k <= FC; k++) begin
            bus_read(A_CHG, d);
            @(negedge clk); pad_in[0] = ~pad_in[0];
            repeat (k) @(negedge clk);
            pad_in[0] = ~pad_in[0];
            repeat (12) @(negedge clk);
            bus_read(A_CHG, d);
            chk($sformatf("R9 pulse %0d", k), d, (k >= FC) ? 32'h1 : 32'h0);
        end
        bus_write(A_FLT_CLR, 32'h01);

        // R7 / R8 pad drive sweep on line 0
        for (int c = 0; c < 64; c++) begin
            put_bit(A_OWN_SET, A_OWN_CLR, c[0]);
            put_bit(A_OE_SET, A_OE_CLR, c[1]);
            put_bit(A_DO_SET, A_DO_CLR, c[2]);
            put_bit(A_OD_SET, A_OD_CLR, c[3]);
            @(negedge clk);
            per_out[0] = c[4]; per_oe[0] = c[5];
            #1;
            exp_o = {31'b0, c[0] ? c[2] : c[4]};
            exp_e = {31'b0, c[0] ? c[1] : c[5]};
            if (c[3]) begin
                exp_e = exp_e & ~exp_o;
                exp_o = 0;
                chk($sformatf("R8 out c%0d", c), {31'b0, pad_out[0]}, exp_o);
                chk($sformatf("R8 oe c%0d", c), {31'b0, pad_oe[0]}, exp_e);
            end else begin
                chk($sformatf("R7 out c%0d", c), {31'b0, pad_out[0]}, exp_o);
                chk($sformatf("R7 oe c%0d", c), {31'b0, pad_oe[0]}, exp_e);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule